// File: doc/BRIEF.md
# Interrupt Core-Map Route Decoder

This block keeps the destination core of every interrupt source in a 256-source interrupt controller. Software sends 32-bit routing words. Each word carries one byte-wide field for each of four consecutive IRQs. A mode input selects how a field is read. In one mode the field is a one-hot core mask. In the other mode the field is a plain binary core number. The decoded core is stored for each IRQ, and a lookup port returns the stored route of any IRQ without a clock delay.

Routes that actually change are reported one at a time on a change strobe. Each report gives the IRQ number, the previous core and the new core, so that logic downstream can move pending state from one core to the other. The write port holds its ready signal low until every report from the previous word has been presented.

Top module: `irq_route_map`

## Requirements
- R1: After reset every stored route is core 0, `wr_ready` is high and `chg_valid` is low.
- R2: A word accepted on `wr_group` = g updates IRQs 4g to 4g+3. Bits 7:0 go to IRQ 4g, bits 15:8 to IRQ 4g+1, bits 23:16 to IRQ 4g+2 and bits 31:24 to IRQ 4g+3.
- R3: When `raw_mode` is 0, the core index is the bit position of the lowest set bit in the field.
- R4: When `raw_mode` is 0, a field that is zero, or whose lowest set bit is at position 4 or higher, decodes to core 0.
- R5: When `raw_mode` is 1, the field value is taken as the core number.
- R6: An IRQ whose decoded core equals its stored route produces no report. A word that changes no route leaves `wr_ready` high.
- R7: Changed IRQs are reported one per cycle, starting the cycle after the word is accepted, in ascending IRQ order. Each report carries `chg_irq`, `chg_old` (the previous route) and `chg_new` (the new route).
- R8: `wr_ready` is low while reports are outstanding and returns high in the cycle after the last report. A word presented while `wr_ready` is low is ignored.
- R9: `lk_core` returns the stored route of `lk_irq` combinationally and reflects a new route from the cycle after the word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_mode | input | 1 | 1: fields are binary core numbers; 0: fields are one-hot masks |
| wr_valid | input | 1 | Routing word present |
| wr_ready | output | 1 | Word can be accepted |
| wr_group | input | 6 | Index of the four-IRQ group |
| wr_data | input | 32 | Four routing fields |
| lk_irq | input | 8 | IRQ to look up |
| lk_core | output | 8 | Stored route of `lk_irq` |
| chg_valid | output | 1 | A route-change report is presented |
| chg_irq | output | 8 | IRQ whose route changed |
| chg_old | output | 8 | Previous core |
| chg_new | output | 8 | New core |

## Verification
The assertions check on every cycle the following properties:
- one-hot decoding never yields a core of 4 or more;
- a report never pairs equal old and new cores;
- a word that changes nothing is followed by no report;
- the outstanding reports drain by exactly one per cycle;
- a reported new core matches what the lookup port returns for that IRQ.

Only the bench scenarios can show the remaining behaviour:
- that each byte lands on the correct IRQ;
- that the lowest set bit wins when several bits are set;
- that reports come out in ascending order with the correct old values;
- that a word offered during a stall leaves no trace.

// File: rtl/irq_route_pkg.sv
// Shared sizing and types for the interrupt route decoder.
// Assumes fields and cores are byte-wide unless overridden at the top.
package irq_route_pkg;
    localparam int FIELD_W_DEF = 8;
    localparam int CORE_W_DEF  = 8;
    localparam int LANES_DEF   = 4;

    // Mode of field interpretation.
    typedef enum logic {
        DEC_ONEHOT = 1'b0,
        DEC_RAW    = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/route_decode.sv
// Turns one routing field into a core index.
// In one-hot mode the lowest set bit wins. A zero field, or an index at or
// above ONEHOT_CORES, falls back to core 0. In raw mode the field is the
// core number. Assumes CORE_W >= FIELD_W.
module route_decode #(
    parameter int FIELD_W      = 8,
    parameter int CORE_W       = 8,
    parameter int ONEHOT_CORES = 4
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               raw_mode,
    output logic [CORE_W-1:0]  core
);
    import irq_route_pkg::*;

    int lowest;

    // Find the position of the lowest set bit by scanning from the top down.
    always_comb begin
        lowest = FIELD_W;
        for (int b = FIELD_W - 1; b >= 0; b--) begin
            if (field[b]) lowest = b;
        end
    end

    // Select the core according to the decode mode.
    always_comb begin
        if (dec_mode_e'(raw_mode) == DEC_RAW) begin
            core = CORE_W'(field);
        end else if (lowest >= ONEHOT_CORES) begin
            core = '0;
        end else begin
            core = CORE_W'(lowest);
        end
    end
endmodule

// File: rtl/route_store.sv
// Holds one route per IRQ. It writes a whole group of LANES routes in
// one cycle and offers two read ports: the group currently addressed for
// writing, and a free lookup port. Assumes NUM_IRQ is a power of two.
module route_store #(
    parameter int NUM_IRQ = 256,
    parameter int CORE_W  = 8,
    parameter int LANES   = 4,
    localparam int IRQ_W  = $clog2(NUM_IRQ),
    localparam int GRP_W  = IRQ_W - $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [GRP_W-1:0]             grp,
    input  logic [LANES-1:0][CORE_W-1:0] wr_core,
    output logic [LANES-1:0][CORE_W-1:0] grp_core,
    input  logic [IRQ_W-1:0]             lk_irq,
    output logic [CORE_W-1:0]            lk_core
);
    logic [CORE_W-1:0] routes [NUM_IRQ];

    // Clear all routes on reset; write the addressed group when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_IRQ; n++) routes[n] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++) routes[int'(grp) * LANES + l] <= wr_core[l];
        end
    end

    // Read the routes of the group being written.
    always_comb begin
        for (int l = 0; l < LANES; l++) grp_core[l] = routes[int'(grp) * LANES + l];
    end

    // Lookup port, combinational.
    assign lk_core = routes[lk_irq];
endmodule

// File: rtl/change_seq.sv
// Captures the changed lanes of one accepted word and presents them
// one per cycle, lowest lane first. It is busy while any lane is still
// pending. Assumes load is only raised when not busy.
module change_seq #(
    parameter int LANES  = 4,
    parameter int CORE_W = 8,
    parameter int GRP_W  = 6,
    localparam int LANE_W = $clog2(LANES),
    localparam int IRQ_W  = GRP_W + LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [LANES-1:0]             load_mask,
    input  logic [GRP_W-1:0]             load_grp,
    input  logic [LANES-1:0][CORE_W-1:0] load_old,
    input  logic [LANES-1:0][CORE_W-1:0] load_new,
    output logic                         busy,
    output logic                         rpt_valid,
    output logic [IRQ_W-1:0]             rpt_irq,
    output logic [CORE_W-1:0]            rpt_old,
    output logic [CORE_W-1:0]            rpt_new
);
    logic [LANES-1:0]             pend_q;
    logic [GRP_W-1:0]             grp_q;
    logic [LANES-1:0][CORE_W-1:0] old_q;
    logic [LANES-1:0][CORE_W-1:0] new_q;
    logic [LANE_W-1:0]            pick;

    // Choose the lowest pending lane.
    always_comb begin
        pick = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pend_q[l]) pick = LANE_W'(l);
        end
    end

    // Load a new set of changes, or retire the lane just reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            grp_q  <= '0;
            old_q  <= '0;
            new_q  <= '0;
        end else if (load) begin
            pend_q <= load_mask;
            grp_q  <= load_grp;
            old_q  <= load_old;
            new_q  <= load_new;
        end else if (|pend_q) begin
            pend_q[pick] <= 1'b0;
        end
    end

    assign busy      = |pend_q;
    assign rpt_valid = |pend_q;
    assign rpt_irq   = {grp_q, pick};
    assign rpt_old   = old_q[pick];
    assign rpt_new   = new_q[pick];

    // R7: while draining with no new load, exactly one lane retires each cycle.
    a_r7_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_q) && !load) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

    // R6: a reported change never pairs equal cores.
    a_r6_report_differs: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_old != rpt_new));
endmodule

// File: rtl/irq_route_map.sv
// Top of the interrupt route decoder. It decodes each field of an
// accepted word, compares the results with the stored routes, writes the
// group, and hands the changed lanes to the report sequencer. Writes stall
// while reports are outstanding. Assumes raw_mode is stable in the accept cycle.
module irq_route_map #(
    parameter int NUM_IRQ      = 256,
    parameter int CORE_W       = irq_route_pkg::CORE_W_DEF,
    parameter int FIELD_W      = irq_route_pkg::FIELD_W_DEF,
    parameter int LANES        = irq_route_pkg::LANES_DEF,
    parameter int ONEHOT_CORES = 4,
    localparam int IRQ_W       = $clog2(NUM_IRQ),
    localparam int GRP_W       = IRQ_W - $clog2(LANES),
    localparam int WORD_W      = FIELD_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [GRP_W-1:0]  wr_group,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IRQ_W-1:0]  lk_irq,
    output logic [CORE_W-1:0] lk_core,
    output logic              chg_valid,
    output logic [IRQ_W-1:0]  chg_irq,
    output logic [CORE_W-1:0] chg_old,
    output logic [CORE_W-1:0] chg_new
);
    logic                         fire;
    logic                         busy;
    logic [LANES-1:0][CORE_W-1:0] lane_core;
    logic [LANES-1:0][CORE_W-1:0] cur_core;
    logic [LANES-1:0]             chg_mask;

    assign wr_ready = !busy;
    assign fire     = wr_valid && wr_ready;

    // One decoder and one comparison per field.
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        route_decode #(
            .FIELD_W      (FIELD_W),
            .CORE_W       (CORE_W),
            .ONEHOT_CORES (ONEHOT_CORES)
        ) dec_i (
            .field    (wr_data[gl*FIELD_W +: FIELD_W]),
            .raw_mode (raw_mode),
            .core     (lane_core[gl])
        );

        assign chg_mask[gl] = (lane_core[gl] != cur_core[gl]);

        // R4: a one-hot decode never produces a core outside the one-hot range.
        a_r4_onehot_range: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && !raw_mode) |-> (lane_core[gl] < CORE_W'(ONEHOT_CORES)));
    end

    route_store #(
        .NUM_IRQ (NUM_IRQ),
        .CORE_W  (CORE_W),
        .LANES   (LANES)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (fire),
        .grp      (wr_group),
        .wr_core  (lane_core),
        .grp_core (cur_core),
        .lk_irq   (lk_irq),
        .lk_core  (lk_core)
    );

    change_seq #(
        .LANES  (LANES),
        .CORE_W (CORE_W),
        .GRP_W  (GRP_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire),
        .load_mask (chg_mask),
        .load_grp  (wr_group),
        .load_old  (cur_core),
        .load_new  (lane_core),
        .busy      (busy),
        .rpt_valid (chg_valid),
        .rpt_irq   (chg_irq),
        .rpt_old   (chg_old),
        .rpt_new   (chg_new)
    );

    // R6: a word that changes no route is followed by no report.
    a_r6_idle_when_same: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (chg_mask == '0)) |=> !chg_valid);

    // R9: the reported new core is what the lookup port now returns.
    a_r9_new_matches_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid && (lk_irq == chg_irq)) |-> (lk_core == chg_new));
endmodule

// File: tb/irq_route_map_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_route_map_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_mode = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [5:0]  wr_group = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  lk_irq = '0;
    logic [7:0]  lk_core;
    logic        chg_valid;
    logic [7:0]  chg_irq;
    logic [7:0]  chg_old;
    logic [7:0]  chg_new;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_route_map dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_mode  (raw_mode),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_group  (wr_group),
        .wr_data   (wr_data),
        .lk_irq    (lk_irq),
        .lk_core   (lk_core),
        .chg_valid (chg_valid),
        .chg_irq   (chg_irq),
        .chg_old   (chg_old),
        .chg_new   (chg_new)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected decode, written from the requirements.
    function automatic logic [7:0] expect_core(input logic [7:0] f, input bit raw);
        if (raw) return f;
        for (int b = 0; b < 8; b++) begin
            if (f[b]) return (b < 4) ? 8'(b) : 8'd0;
        end
        return 8'd0;
    endfunction

    task automatic look(input string req, input int irq, input int exp);
        lk_irq = 8'(irq);
        #1;
        chk(req, $sformatf("lookup irq %0d", irq), int'(lk_core), exp);
    endtask

    // Apply one word. When hold_other is set, a different word stays offered
    // while the block is stalled.
    task automatic apply(input string req, input int grp, input logic [31:0] data,
                         input bit raw, input bit hold_other);
        logic [7:0] nv [4];
        int n_chg = 0;
        for (int l = 0; l < 4; l++) begin
            nv[l] = expect_core(data[l*8 +: 8], raw);
            if (nv[l] != model[grp*4 + l]) n_chg++;
        end
        @(negedge clk);
        chk("R8", "ready before write", int'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_group = 6'(grp);
        wr_data  = data;
        raw_mode = raw;
        @(negedge clk);
        if (hold_other) begin
            wr_group = 6'((grp + 1) % 64);
            wr_data  = 32'h0909_0909;
        end else begin
            wr_valid = 1'b0;
        end
        // R7: reports in ascending order, one per cycle.
        for (int l = 0; l < 4; l++) begin
            if (nv[l] != model[grp*4 + l]) begin
                chk("R7", "chg_valid", int'(chg_valid), 1);
                chk("R7", "chg_irq", int'(chg_irq), grp*4 + l);
                chk("R7", "chg_old", int'(chg_old), int'(model[grp*4 + l]));
                chk("R7", "chg_new", int'(chg_new), int'(nv[l]));
                chk("R8", "ready while reporting", int'(wr_ready), 0);
                lk_irq = 8'(grp*4 + l);
                #1;
                chk("R9", "lookup during report", int'(lk_core), int'(nv[l]));
                @(negedge clk);
            end
        end
        wr_valid = 1'b0;
        chk(n_chg == 0 ? "R6" : "R7", "chg_valid after drain", int'(chg_valid), 0);
        chk("R8", "ready after drain", int'(wr_ready), 1);
        for (int l = 0; l < 4; l++) begin
            model[grp*4 + l] = nv[l];
            look(req, grp*4 + l, int'(nv[l]));
        end
    endtask

    task automatic t_reset;
        chk("R1", "ready", int'(wr_ready), 1);
        chk("R1", "chg_valid", int'(chg_valid), 0);
        look("R1", 0, 0);
        look("R1", 77, 0);
        look("R1", 255, 0);
    endtask

    task automatic t_onehot;
        // R2 R3: bytes 0x01,0x08,0x04,0x02 from low to high give cores 0,3,2,1.
        apply("R3", 3, 32'h0204_0801, 1'b0, 1'b0);
        look("R2", 11, 0);
        look("R2", 16, 0);
        // R3: several bits set, the lowest wins: 0x0C gives core 2.
        apply("R3", 10, 32'h0000_0C00, 1'b0, 1'b0);
    endtask

    task automatic t_onehot_oob;
        // R4: 0x10, 0x00, 0x80 give core 0; 0x06 gives core 1.
        apply("R4", 3, 32'h0680_0010, 1'b0, 1'b0);
    endtask

    task automatic t_raw;
        // R5: the bytes are core numbers 255, 5, 0 and 128.
        apply("R5", 63, 32'h8000_05FF, 1'b1, 1'b0);
        // R5: the same byte 0x03 decodes differently in each mode.
        apply("R5", 20, 32'h0000_0003, 1'b1, 1'b0);
        apply("R4", 20, 32'h0000_0003, 1'b0, 1'b0);
    endtask

    task automatic t_same;
        // R6: rewriting identical routes gives no reports and no stall.
        apply("R6", 63, 32'h8000_05FF, 1'b1, 1'b0);
        apply("R6", 40, 32'h0000_0000, 1'b0, 1'b0);
    endtask

    task automatic t_stall;
        // R8: a word held on the port during the stall must be ignored.
        apply("R8", 5, 32'h0403_0201, 1'b1, 1'b1);
        @(negedge clk);
        chk("R8", "no stray report", int'(chg_valid), 0);
        for (int l = 0; l < 4; l++) look("R8", 24 + l, 0);
    endtask

    initial begin
        for (int n = 0; n < 256; n++) model[n] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_onehot();
        t_onehot_oob();
        t_raw();
        t_same();
        t_stall();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule